// File: doc/BRIEF.md
# Descriptor Ring Prefetch and Writeback Engine

This block works on a circular ring of 16-byte descriptors that lives in host memory. Software sets the ring's base address, its length in bytes, the starting head index, and a tail index it moves forward as it posts work. The engine reads descriptors ahead of need into a small on-chip cache, following a private cache pointer. It hands the cached descriptors to a consumer one at a time. Each descriptor it gets back is kept in a used queue.

When asked to, the engine writes the used descriptors back to memory as one burst and then advances the head index. A writeback request carries an alignment mask that can shorten the burst. A burst that would run past the end of the ring is cut at the end and followed by a second burst from index 0. A request with a less restrictive mask that arrives while a burst is in flight is remembered and issued after that burst completes. A sticky flag records any change to the ring geometry or head while the cache holds descriptors.

Top module: `drp_engine`

## Requirements
- R1: The ring length in descriptors is the byte length input divided by 16. Descriptor index i is addressed at base + 16*i on both the read and the write request channels.
- R2: A fetch starts at the cache pointer. If tail >= cache pointer it covers the entries up to tail, and if tail < cache pointer it covers the entries up to the ring end. No fetch is made when tail equals the cache pointer.
- R3: The fetch count never exceeds the free cache slots: CAP minus the used, unused and consumer-held descriptors.
- R4: At most one fetch is outstanding. Its response beats are queued in arrival order, and at completion the cache pointer advances by the count, wrapping modulo the ring length.
- R5: The consumer sees descriptors in fetch order, one at a time. No new descriptor is offered until the held one is returned, and returned descriptors are written back in return order.
- R6: A writeback covers head up to head + used. When that target exceeds the ring length, the burst stops at the ring end and a follow-up burst is issued once it completes.
- R7: With no clipping and a nonzero mask, the target has the bits of (mask >> 4) cleared. If the result is not above head, no burst is issued.
- R8: At most one writeback is outstanding. A request that arrives during a burst with a numerically smaller mask is issued, with that mask, after the burst completes.
- R9: On writeback completion head advances by the burst count and becomes 0 when it reaches the ring length.
- R10: No fetch or writeback request is ever issued with a count of zero.
- R11: Changing base or length, or loading head, while any descriptor is cached, held or being fetched sets `cfg_err`. The flag stays set until reset, and the same changes made while the cache is empty leave it clear.
- R12: After reset both queues are empty, head and cache pointer are 0, no request is active, and `cfg_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | ADDR_W | Ring base byte address |
| cfg_len | input | IDX_W+4 | Ring length in bytes |
| cfg_tail | input | IDX_W | Tail index posted by software |
| head_load | input | 1 | Load head and cache pointer from head_val |
| head_val | input | IDX_W | Head value to load |
| rd_req_valid | output | 1 | One-cycle descriptor read request |
| rd_req_addr | output | ADDR_W | Read start address |
| rd_req_cnt | output | CNT_W | Descriptors to read |
| rd_rsp_valid | input | 1 | One descriptor beat returned |
| rd_rsp_data | input | DESC_W | Descriptor beat |
| wr_req_valid | output | 1 | One-cycle writeback request |
| wr_req_addr | output | ADDR_W | Writeback start address |
| wr_req_cnt | output | CNT_W | Descriptors to write |
| wr_data_rd | input | 1 | Pull the next writeback beat |
| wr_data | output | DESC_W | Oldest used descriptor |
| wr_done | input | 1 | Writeback burst finished |
| wb_req | input | 1 | Request a writeback |
| wb_mask | input | IDX_W+4 | Alignment mask for that request |
| cons_valid | output | 1 | A descriptor is offered |
| cons_data | output | DESC_W | Offered descriptor |
| cons_take | input | 1 | Consumer takes the offered descriptor |
| ret_valid | input | 1 | Consumer returns the held descriptor |
| ret_data | input | DESC_W | Returned descriptor contents |
| ring_head | output | IDX_W | Current head index |
| cache_ptr | output | IDX_W | Next index to prefetch |
| used_cnt | output | CNT_W | Descriptors waiting for writeback |
| unused_cnt | output | CNT_W | Prefetched descriptors not yet offered |
| cfg_err | output | 1 | Sticky illegal-change flag |

## Verification
The bench sweeps fetch windows in which tail is ahead of, behind and equal to the cache pointer, plus one case where free cache space is smaller than the window. A design that ignored the wrap would fetch past the ring end, and one that ignored free space would overflow its queue. Directed runs cover a writeback that straddles the ring end, which a faulty design would write past the ring or never finish. They cover a mask that rounds the target below head, where a faulty design would issue a bogus or zero burst. They also cover a smaller mask posted mid-burst, which would be lost without the remembered follow-up. The error flag is checked in both directions: clear for changes to an empty cache, and set and staying set for a change under a non-empty one.

// File: rtl/drp_pkg.sv
package drp_pkg;
    // bytes per descriptor = 1 << DESC_SHIFT
    localparam int DESC_SHIFT = 4;
    localparam int DEF_ADDR_W = 32;
    localparam int DEF_IDX_W  = 8;
    localparam int DEF_DESC_W = 128;
    localparam int DEF_CAP    = 8;

    typedef enum logic {
        WB_IDLE = 1'b0,
        WB_BUSY = 1'b1
    } wb_state_e;
endpackage

// File: rtl/drp_fifo.sv
module drp_fifo #(
    parameter int W     = 128,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) begin
                mem[wp] <= din;
                wp      <= bump(wp);
            end
            if (pop) rp <= bump(rp);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign dout = mem[rp];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push && !pop |-> count < CNT_W'(DEPTH)); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop |-> count != '0); // R5
endmodule

// File: rtl/drp_fetch.sv
module drp_fetch
    import drp_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int IDX_W  = DEF_IDX_W,
    parameter int CAP    = DEF_CAP,
    localparam int CNT_W = $clog2(CAP + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  len,
    input  logic [IDX_W-1:0]  tail,
    input  logic              load,
    input  logic [IDX_W-1:0]  load_val,
    input  logic [CNT_W-1:0]  occ,
    input  logic              rsp_valid,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [CNT_W-1:0]  req_cnt,
    output logic              busy,
    output logic [IDX_W-1:0]  cp
);
    logic [CNT_W-1:0] free_c, cnt_c, beats;
    logic [IDX_W-1:0] avail_c;
    logic [IDX_W:0]   cp_sum;
    logic             issue;

    always_comb begin
        free_c  = CNT_W'(CAP) - occ;
        avail_c = (tail >= cp) ? tail - cp : len - cp;
        cnt_c   = (IDX_W'(free_c) < avail_c) ? free_c : avail_c[CNT_W-1:0];
        issue   = !busy && !load && (len != '0) && (cnt_c != '0);
        cp_sum  = {1'b0, cp} + (IDX_W+1)'(req_cnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            req_valid <= 1'b0;
            req_addr  <= '0;
            req_cnt   <= '0;
            beats     <= '0;
            cp        <= '0;
        end else begin
            req_valid <= 1'b0;
            if (load) cp <= load_val;
            if (issue) begin
                busy      <= 1'b1;
                req_valid <= 1'b1;
                req_addr  <= base + (ADDR_W'(cp) << DESC_SHIFT);
                req_cnt   <= cnt_c;
                beats     <= '0;
            end else if (busy && rsp_valid) begin
                beats <= beats + 1'b1;
                if (beats + 1'b1 == req_cnt) begin
                    busy <= 1'b0;
                    cp   <= (cp_sum >= {1'b0, len}) ? IDX_W'(cp_sum - {1'b0, len})
                                                    : cp_sum[IDX_W-1:0];
                end
            end
        end
    end

    AST_FETCH_NONZERO: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> req_cnt != '0); // R10
    AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !req_valid); // R4
endmodule

// File: rtl/drp_wb.sv
module drp_wb
    import drp_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int IDX_W  = DEF_IDX_W,
    parameter int CAP    = DEF_CAP,
    localparam int CNT_W = $clog2(CAP + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  len,
    input  logic [CNT_W-1:0]  used,
    input  logic              load,
    input  logic [IDX_W-1:0]  load_val,
    input  logic              req,
    input  logic [IDX_W+3:0]  mask,
    input  logic              done,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [CNT_W-1:0]  req_cnt,
    output logic [IDX_W-1:0]  head
);
    wb_state_e        st;
    logic             more, retry, more_n, start, clip;
    logic [IDX_W+3:0] mask_r, sel_mask;
    logic [IDX_W-1:0] m;
    logic [IDX_W:0]   tgt, tgt_al, c, hsum;

    always_comb begin
        sel_mask = req ? mask : mask_r;
        m        = sel_mask[IDX_W+3:DESC_SHIFT];
        tgt      = {1'b0, head} + (IDX_W+1)'(used);
        tgt_al   = tgt & ~{1'b0, m};
        clip     = tgt > {1'b0, len};
        if (clip)
            c = {1'b0, len} - {1'b0, head};
        else if (m != '0)
            c = (tgt_al > {1'b0, head}) ? tgt_al - {1'b0, head} : '0;
        else
            c = (IDX_W+1)'(used);
        start  = (st == WB_IDLE) && !load && (req || retry);
        more_n = more || (req && (st == WB_BUSY) && (mask < mask_r));
        hsum   = {1'b0, head} + (IDX_W+1)'(req_cnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= WB_IDLE;
            more      <= 1'b0;
            retry     <= 1'b0;
            mask_r    <= '0;
            req_valid <= 1'b0;
            req_addr  <= '0;
            req_cnt   <= '0;
            head      <= '0;
        end else begin
            req_valid <= 1'b0;
            if (load) head <= load_val;
            if (start) begin
                retry  <= 1'b0;
                mask_r <= sel_mask;
                if (c != '0) begin
                    st        <= WB_BUSY;
                    req_valid <= 1'b1;
                    req_addr  <= base + (ADDR_W'(head) << DESC_SHIFT);
                    req_cnt   <= CNT_W'(c);
                    more      <= clip;
                end else begin
                    more <= 1'b0;
                end
            end else if (st == WB_BUSY) begin
                if (req && mask < mask_r) mask_r <= mask;
                if (done) begin
                    st    <= WB_IDLE;
                    head  <= (hsum >= {1'b0, len}) ? '0 : hsum[IDX_W-1:0];
                    retry <= more_n;
                    more  <= 1'b0;
                end else begin
                    more <= more_n;
                end
            end
        end
    end

    AST_WB_IN_RING: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_cnt != '0) && ({1'b0, head} + (IDX_W+1)'(req_cnt) <= {1'b0, len})); // R6
    AST_HEAD_STABLE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (st == WB_BUSY) && !done && !load |=> $stable(head)); // R9
endmodule

// File: rtl/drp_engine.sv
module drp_engine
    import drp_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int IDX_W  = DEF_IDX_W,
    parameter int DESC_W = DEF_DESC_W,
    parameter int CAP    = DEF_CAP,
    localparam int CNT_W = $clog2(CAP + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [IDX_W+3:0]  cfg_len,
    input  logic [IDX_W-1:0]  cfg_tail,
    input  logic              head_load,
    input  logic [IDX_W-1:0]  head_val,
    output logic              rd_req_valid,
    output logic [ADDR_W-1:0] rd_req_addr,
    output logic [CNT_W-1:0]  rd_req_cnt,
    input  logic              rd_rsp_valid,
    input  logic [DESC_W-1:0] rd_rsp_data,
    output logic              wr_req_valid,
    output logic [ADDR_W-1:0] wr_req_addr,
    output logic [CNT_W-1:0]  wr_req_cnt,
    input  logic              wr_data_rd,
    output logic [DESC_W-1:0] wr_data,
    input  logic              wr_done,
    input  logic              wb_req,
    input  logic [IDX_W+3:0]  wb_mask,
    output logic              cons_valid,
    output logic [DESC_W-1:0] cons_data,
    input  logic              cons_take,
    input  logic              ret_valid,
    input  logic [DESC_W-1:0] ret_data,
    output logic [IDX_W-1:0]  ring_head,
    output logic [IDX_W-1:0]  cache_ptr,
    output logic [CNT_W-1:0]  used_cnt,
    output logic [CNT_W-1:0]  unused_cnt,
    output logic              cfg_err
);
    logic [IDX_W-1:0]  len;
    logic [CNT_W-1:0]  occ;
    logic              held, fetch_busy, take, give_back, cfg_change;
    logic [ADDR_W-1:0] prev_base;
    logic [IDX_W+3:0]  prev_len;

    assign len        = cfg_len[IDX_W+3:DESC_SHIFT];
    assign occ        = used_cnt + unused_cnt + CNT_W'(held);
    assign cons_valid = (unused_cnt != '0) && !held;
    assign take       = cons_take && cons_valid;
    assign give_back  = ret_valid && held;
    assign cfg_change = (cfg_base != prev_base) || (cfg_len != prev_len) || head_load;

    drp_fifo #(.W(DESC_W), .DEPTH(CAP)) u_unused (
        .clk(clk), .rst(rst),
        .push(rd_rsp_valid && fetch_busy), .din(rd_rsp_data),
        .pop(take), .dout(cons_data), .count(unused_cnt)
    );

    drp_fifo #(.W(DESC_W), .DEPTH(CAP)) u_used (
        .clk(clk), .rst(rst),
        .push(give_back), .din(ret_data),
        .pop(wr_data_rd), .dout(wr_data), .count(used_cnt)
    );

    drp_fetch #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CAP(CAP)) u_fetch (
        .clk(clk), .rst(rst), .base(cfg_base), .len(len), .tail(cfg_tail),
        .load(head_load), .load_val(head_val), .occ(occ),
        .rsp_valid(rd_rsp_valid), .req_valid(rd_req_valid),
        .req_addr(rd_req_addr), .req_cnt(rd_req_cnt),
        .busy(fetch_busy), .cp(cache_ptr)
    );

    drp_wb #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CAP(CAP)) u_wb (
        .clk(clk), .rst(rst), .base(cfg_base), .len(len), .used(used_cnt),
        .load(head_load), .load_val(head_val), .req(wb_req), .mask(wb_mask),
        .done(wr_done), .req_valid(wr_req_valid), .req_addr(wr_req_addr),
        .req_cnt(wr_req_cnt), .head(ring_head)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            held      <= 1'b0;
            cfg_err   <= 1'b0;
            prev_base <= cfg_base;
            prev_len  <= cfg_len;
        end else begin
            prev_base <= cfg_base;
            prev_len  <= cfg_len;
            if (take)           held <= 1'b1;
            else if (give_back) held <= 1'b0;
            if (cfg_change && ((occ != '0) || fetch_busy)) cfg_err <= 1'b1;
        end
    end

    AST_FETCH_FITS: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |-> (CNT_W+1)'(rd_req_cnt) + (CNT_W+1)'(occ) <= (CNT_W+1)'(CAP)); // R3
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err); // R11
    AST_ONE_HELD: assert property (@(posedge clk) disable iff (rst)
        held && !give_back |=> !cons_valid); // R5
endmodule

// File: tb/test_drp_engine.sv
module test_drp_engine;
    localparam int ADDR_W = 32, IDX_W = 8, DESC_W = 128, CAP = 8;
    localparam int CNT_W = $clog2(CAP + 1);

    logic              clk = 1'b0;
    logic              rst;
    logic [ADDR_W-1:0] cfg_base;
    logic [IDX_W+3:0]  cfg_len, wb_mask;
    logic [IDX_W-1:0]  cfg_tail, head_val, ring_head, cache_ptr;
    logic              head_load, rd_req_valid, rd_rsp_valid, wr_req_valid;
    logic              wr_data_rd, wr_done, wb_req, cons_valid, cons_take, ret_valid, cfg_err;
    logic [ADDR_W-1:0] rd_req_addr, wr_req_addr;
    logic [CNT_W-1:0]  rd_req_cnt, wr_req_cnt, used_cnt, unused_cnt;
    logic [DESC_W-1:0] rd_rsp_data, wr_data, cons_data, ret_data;

    int tests = 0, fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    drp_engine #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DESC_W(DESC_W), .CAP(CAP)) i_drp_engine (
        .clk, .rst, .cfg_base, .cfg_len, .cfg_tail, .head_load, .head_val,
        .rd_req_valid, .rd_req_addr, .rd_req_cnt, .rd_rsp_valid, .rd_rsp_data,
        .wr_req_valid, .wr_req_addr, .wr_req_cnt, .wr_data_rd, .wr_data, .wr_done,
        .wb_req, .wb_mask, .cons_valid, .cons_data, .cons_take, .ret_valid, .ret_data,
        .ring_head, .cache_ptr, .used_cnt, .unused_cnt, .cfg_err
    );

    // {len, head, tail, expected count, expected address}
    localparam logic [43:0] VEC [0:5] = '{
        {8'd16, 8'd0,  8'd5,  4'd5, 16'h1000},
        {8'd16, 8'd3,  8'd15, 4'd8, 16'h1030},
        {8'd16, 8'd12, 8'd2,  4'd4, 16'h10C0},
        {8'd16, 8'd14, 8'd3,  4'd2, 16'h10E0},
        {8'd16, 8'd7,  8'd7,  4'd0, 16'h0000},
        {8'd4,  8'd1,  8'd0,  4'd3, 16'h1010}
    };

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1; cfg_base = '0; cfg_len = '0; cfg_tail = '0; head_load = 0; head_val = '0;
        rd_rsp_valid = 0; rd_rsp_data = '0; wr_data_rd = 0; wr_done = 0; wb_req = 0;
        wb_mask = '0; cons_take = 0; ret_valid = 0; ret_data = '0;
        step(); step();
        rst = 0;
        step();
    endtask

    task automatic setup(input logic [31:0] base, input int len, input int head, input int tail);
        cfg_base = base; cfg_len = 12'(len * 16);
        step();
        head_load = 1; head_val = 8'(head); cfg_tail = 8'(tail);
        step();
        head_load = 0;
    endtask

    task automatic wait_rd(output bit got);
        got = 0;
        for (int i = 0; i < 6 && !got; i++) begin
            if (rd_req_valid) got = 1; else step();
        end
    endtask

    task automatic wait_wr(output bit got);
        got = 0;
        for (int i = 0; i < 6 && !got; i++) begin
            if (wr_req_valid) got = 1; else step();
        end
    endtask

    task automatic respond(input int n, input int first);
        step();
        for (int i = 0; i < n; i++) begin
            rd_rsp_valid = 1; rd_rsp_data = 128'(first + i);
            step();
        end
        rd_rsp_valid = 0;
        step();
    endtask

    task automatic cycle_desc(input int n, input int first, input int add, input string req);
        for (int i = 0; i < n; i++) begin
            check(req, cons_valid, 1);
            check(req, cons_data, 128'(first + i));
            cons_take = 1;
            step();
            cons_take = 0;
            check("R5 held blocks offer", cons_valid, 0);
            ret_valid = 1; ret_data = 128'(first + i + add);
            step();
            ret_valid = 0;
        end
        step();
    endtask

    task automatic drain(input int n, input int first, input string req);
        for (int i = 0; i < n; i++) begin
            check(req, wr_data, 128'(first + i));
            wr_data_rd = 1;
            step();
        end
        wr_data_rd = 0;
        wr_done = 1;
        step();
        wr_done = 0;
    endtask

    task automatic post_wb(input logic [11:0] mask);
        wb_req = 1; wb_mask = mask;
        step();
        wb_req = 0;
    endtask

    initial begin
        bit got;
        do_reset();
        // R12: reset state
        check("R12 head", ring_head, 0);
        check("R12 cache_ptr", cache_ptr, 0);
        check("R12 used", used_cnt, 0);
        check("R12 unused", unused_cnt, 0);
        check("R12 err", cfg_err, 0);
        check("R12 no req", {rd_req_valid, wr_req_valid, cons_valid}, 0);

        // R1 R2 R3 R10: fetch window table
        foreach (VEC[k]) begin
            do_reset();
            setup(32'h1000, int'(VEC[k][43:36]), int'(VEC[k][35:28]), int'(VEC[k][27:20]));
            wait_rd(got);
            check("R2 fetch issued", got, VEC[k][19:16] != 0);
            if (got) begin
                check("R3 fetch count", rd_req_cnt, VEC[k][19:16]);
                check("R1 fetch addr", rd_req_addr, VEC[k][15:0]);
            end
        end

        // R4 R5 R9: basic flow
        do_reset();
        setup(32'h1000, 16, 0, 6);
        wait_rd(got);
        check("R4 fetch req", {got, rd_req_cnt}, {1'b1, 4'd6});
        respond(6, 0);
        check("R4 unused after fetch", unused_cnt, 6);
        check("R4 cache ptr advance", cache_ptr, 6);
        check("R11 no err on empty-cache setup", cfg_err, 0);
        cycle_desc(3, 0, 100, "R5 order");
        check("R5 used count", used_cnt, 3);
        post_wb('0);
        wait_wr(got);
        check("R6 wb req", {got, wr_req_cnt, wr_req_addr}, {1'b1, 4'd3, 32'h1000});
        drain(3, 100, "R5 wb data");
        step();
        check("R9 head advance", ring_head, 3);

        // R7 R8: alignment and remembered follow-up
        cycle_desc(3, 3, 100, "R5 order 2");
        post_wb(12'h040);
        wait_wr(got);
        check("R7 mask rounds below head", got, 0);
        post_wb(12'h020);
        wait_wr(got);
        check("R7 aligned wb", {got, wr_req_cnt, wr_req_addr}, {1'b1, 4'd1, 32'h1030});
        step();
        post_wb('0);
        drain(1, 103, "R7 wb data");
        wait_wr(got);
        check("R8 follow-up wb", {got, wr_req_cnt, wr_req_addr}, {1'b1, 4'd2, 32'h1040});
        drain(2, 104, "R8 wb data");
        step();
        check("R9 head after follow-up", ring_head, 6);

        // R4 R6 R9: wrap and clip
        do_reset();
        setup(32'h2000, 8, 5, 4);
        wait_rd(got);
        check("R2 fetch to ring end", {got, rd_req_cnt, rd_req_addr}, {1'b1, 4'd3, 32'h2050});
        respond(3, 'h50);
        wait_rd(got);
        check("R4 fetch after wrap", {got, rd_req_cnt, rd_req_addr}, {1'b1, 4'd4, 32'h2000});
        respond(4, 'h60);
        check("R4 cache ptr wrapped", cache_ptr, 4);
        cycle_desc(3, 'h50, 'h100, "R5 order wrap a");
        cycle_desc(4, 'h60, 'h100, "R5 order wrap b");
        check("R5 used seven", used_cnt, 7);
        post_wb('0);
        wait_wr(got);
        check("R6 clipped wb", {got, wr_req_cnt, wr_req_addr}, {1'b1, 4'd3, 32'h2050});
        drain(3, 'h150, "R6 clip data");
        check("R9 head wraps to 0", ring_head, 0);
        wait_wr(got);
        check("R6 wb after clip", {got, wr_req_cnt, wr_req_addr}, {1'b1, 4'd4, 32'h2000});
        drain(4, 'h160, "R6 second data");
        step();
        check("R9 head final", ring_head, 4);

        // R11: error flag
        cfg_base = 32'h3000;
        step(); step();
        check("R11 change with empty cache", cfg_err, 0);
        cfg_tail = 8'd6;
        wait_rd(got);
        respond(2, 0);
        cfg_base = 32'h4000;
        step(); step();
        check("R11 change with cached entries", cfg_err, 1);
        cfg_base = 32'h3000;
        step(); step();
        check("R11 sticky", cfg_err, 1);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule